// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Transmit Lane

This block turns parallel words, presented in a slow divided-clock domain, into a serial bit stream timed by a fast clock. One instance accepts up to six parallel bits. It runs in one of two ways. In the 2:1 mode the fast clock runs at twice the divided clock, and the line changes only on rising fast edges. In the 8:1 mode the fast clock runs at four times the divided clock, and the line changes on both fast edges.

Eight bits do not fit in one lane, so the 8:1 mode joins two instances. A master lane carries word bits 0 to 5 on its own data inputs. A slave lane carries bits 6 and 7 on its data inputs at index 2 and 3, and passes them to the master over a two-wire expansion path. Only the master drives the serial line.

Every rising edge of the divided clock captures a word. A toggle flag passes the capture event to the fast domain, and the shifter loads the word on the next rising fast edge. The first bit therefore appears exactly one fast-clock cycle after the capture edge. Words sent back to back leave no gap on the line.

Top module: `txser_lane`

## Requirements
- R1: On each rising edge of `clk_div` with `rst` low, the lane captures `data_in`. The bits sent for that word are the values present at that edge.
- R2: With `mode_ddr` = 0 (2:1 mode), `data_in[0]` drives `serial_q` for the whole fast cycle that starts one rising `clk_fast` edge after the capture edge. `data_in[1]` drives it for the next full fast cycle. Inputs `data_in[5:2]` and `shift_in` have no effect in this mode.
- R3: With `mode_ddr` = 1 (8:1 mode), word bit 2j is on `serial_q` while `clk_fast` is high, and bit 2j+1 is on it during the low half that follows. This gives eight bits in ascending order over four fast cycles.
- R4: In 8:1 mode, word bit 0 appears in the high half of the fast cycle that starts one rising `clk_fast` edge after the capture edge.
- R5: In 8:1 mode, the master sends its own `data_in[0..5]` as word bits 0 to 5. It then sends its `shift_in[0]` and `shift_in[1]` as bits 6 and 7. `shift_out` always equals the captured `data_in[3:2]`, with `shift_out[0]` = `data_in[2]`. The data bits 0, 1, 4 and 5 of a slave have no effect on the master line.
- R6: A lane built with `IS_MASTER` = 0 holds `serial_q` at 0 at all times.
- R7: `rst` (synchronous, active high) clears the lane. `serial_q` is 0 during reset and until the first word captured after reset reaches the line. An all-zero word keeps the line at 0.
- R8: When words arrive on consecutive `clk_div` edges, the bits of each word follow the last bit of the previous word with no idle slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Bit-rate clock: 2x `clk_div` in 2:1 mode, 4x in 8:1 mode |
| clk_div | input | 1 | Divided word clock, rising-edge aligned to `clk_fast` |
| rst | input | 1 | Synchronous active-high reset, seen in both clock domains |
| mode_ddr | input | 1 | 0 = 2:1 single-edge mode, 1 = 8:1 both-edge mode; change only in reset |
| data_in | input | LANE_W (6) | Parallel bits; index 0 is sent first |
| shift_in | input | EXP_W (2) | Expansion bits from the slave, sent as word bits 6 and 7 |
| shift_out | output | EXP_W (2) | Captured `data_in[3:2]`, for the master's `shift_in` |
| serial_q | output | 1 | Serial line, driven only by a master lane |

## Verification
The assertions run on every fast cycle. They check that the shifter's first rising bit matches captured bit 0 one cycle after each load. They check the second bit in both modes, and that the expansion bits leave as the fourth pair in 8:1 mode. They also check that reset clears the output pair and that a slave line stays silent. Only the bench scenarios show the behaviour of the real line. This covers the falling-edge half-slots, exact alignment to the divided-clock edge, and gap-free streaming of consecutive words. It also covers the fixed split between master and slave bits, and that unused slave and high-order inputs are ignored.

// File: rtl/txser_pkg.sv
package txser_pkg;

    localparam int TX_LANE_W   = 6;
    localparam int TX_EXP_W    = 2;
    localparam int TX_EXP_TAP  = 2;
    localparam int TX_DDR_STEP = 2;
    localparam int TX_SDR_STEP = 1;

    typedef enum logic {
        SER_SDR2 = 1'b0,
        SER_DDR8 = 1'b1
    } ser_mode_e;

    typedef struct packed {
        logic even;
        logic odd;
    } ser_pair_t;

    function automatic ser_mode_e decode_mode(input logic ddr);
        return ddr ? SER_DDR8 : SER_SDR2;
    endfunction

    function automatic ser_pair_t make_pair(input logic e, input logic o);
        ser_pair_t p;
        p.even = e;
        p.odd  = o;
        return p;
    endfunction

endpackage

// File: rtl/txser_capture.sv
module txser_capture #(
    parameter int LANE_W = 6
) (
    input  logic              clk_div,
    input  logic              rst,
    input  logic [LANE_W-1:0] data_in,
    output logic [LANE_W-1:0] hold_q,
    output logic              tog_q
);

    // One word per divided-clock rising edge; the toggle marks each capture.
    always_ff @(posedge clk_div) begin
        if (rst) begin
            hold_q <= '0;
            tog_q  <= 1'b0;
        end else begin
            hold_q <= data_in;
            tog_q  <= ~tog_q;
        end
    end

endmodule

// File: rtl/txser_shifter.sv
module txser_shifter
    import txser_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk_fast,
    input  logic              rst,
    input  ser_mode_e         mode,
    input  logic              cap_tog,
    input  logic [WORD_W-1:0] word_i,
    output logic              load_o,
    output ser_pair_t         pair_q
);

    logic              tog_seen;
    logic [WORD_W-1:0] sh_q;

    // A capture in the divided domain is pending until the fast side notes it.
    assign load_o = cap_tog ^ tog_seen;

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            tog_seen <= 1'b0;
            sh_q     <= '0;
            pair_q   <= make_pair(1'b0, 1'b0);
        end else begin
            tog_seen <= cap_tog;
            if (load_o) begin
                if (mode == SER_DDR8) begin
                    pair_q <= make_pair(word_i[0], word_i[1]);
                    sh_q   <= word_i >> TX_DDR_STEP;
                end else begin
                    // Only two bits belong to a 2:1 word; the rest is dropped.
                    pair_q  <= make_pair(word_i[0], word_i[0]);
                    sh_q    <= '0;
                    sh_q[0] <= word_i[1];
                end
            end else begin
                if (mode == SER_DDR8) begin
                    pair_q <= make_pair(sh_q[0], sh_q[1]);
                    sh_q   <= sh_q >> TX_DDR_STEP;
                end else begin
                    pair_q <= make_pair(sh_q[0], sh_q[0]);
                    sh_q   <= sh_q >> TX_SDR_STEP;
                end
            end
        end
    end

endmodule

// File: rtl/txser_line.sv
module txser_line
    import txser_pkg::*;
(
    input  logic      clk_fast,
    input  logic      rst,
    input  ser_pair_t pair_i,
    output logic      line_o
);

    logic fall_q;

    // The odd bit is retimed to the falling edge so it owns the low half.
    always_ff @(negedge clk_fast) begin
        if (rst) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= pair_i.odd;
        end
    end

    // In 2:1 mode even and odd carry the same bit, so one path serves both modes.
    assign line_o = clk_fast ? pair_i.even : fall_q;

endmodule

// File: rtl/txser_lane.sv
module txser_lane
    import txser_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1,
    parameter int LANE_W    = TX_LANE_W,
    parameter int EXP_W     = TX_EXP_W,
    parameter int EXP_TAP   = TX_EXP_TAP
) (
    input  logic              clk_fast,
    input  logic              clk_div,
    input  logic              rst,
    input  logic              mode_ddr,
    input  logic [LANE_W-1:0] data_in,
    input  logic [EXP_W-1:0]  shift_in,
    output logic [EXP_W-1:0]  shift_out,
    output logic              serial_q
);

    localparam int WORD_W = LANE_W + EXP_W;

    ser_mode_e         mode_e;
    logic [LANE_W-1:0] hold_w;
    logic              cap_tog;
    logic [WORD_W-1:0] word_w;
    logic              load_evt;
    ser_pair_t         pair_q;
    logic              line_q;

    assign mode_e = decode_mode(mode_ddr);

    txser_capture #(.LANE_W(LANE_W)) cap_i (
        .clk_div (clk_div),
        .rst     (rst),
        .data_in (data_in),
        .hold_q  (hold_w),
        .tog_q   (cap_tog)
    );

    // Expansion taps: the fixed pair a master appends after its own bits.
    assign shift_out = hold_w[EXP_TAP +: EXP_W];

    generate
        if (IS_MASTER) begin : g_master
            assign word_w   = {shift_in, hold_w};
            assign serial_q = line_q;
        end else begin : g_slave
            assign word_w   = {{EXP_W{1'b0}}, hold_w};
            assign serial_q = 1'b0;
        end
    endgenerate

    txser_shifter #(.WORD_W(WORD_W)) shf_i (
        .clk_fast (clk_fast),
        .rst      (rst),
        .mode     (mode_e),
        .cap_tog  (cap_tog),
        .word_i   (word_w),
        .load_o   (load_evt),
        .pair_q   (pair_q)
    );

    txser_line line_i (
        .clk_fast (clk_fast),
        .rst      (rst),
        .pair_i   (pair_q),
        .line_o   (line_q)
    );

endmodule

// File: rtl/txser_lane_chk.sv
module txser_lane_chk #(
    parameter bit IS_MASTER = 1'b1,
    parameter int EXP_W     = 2
) (
    input logic             clk_fast,
    input logic             rst,
    input logic             mode_ddr,
    input logic             load,
    input logic             hold0,
    input logic             hold1,
    input logic [EXP_W-1:0] shift_in,
    input logic             rise_bit,
    input logic             odd_bit,
    input logic             serial_q
);

    p_first_bit_r2: assert property (@(posedge clk_fast) disable iff (rst)
        load |=> (rise_bit == $past(hold0)));

    p_ddr_odd_r3: assert property (@(posedge clk_fast) disable iff (rst)
        (load && mode_ddr) |=> (odd_bit == $past(hold1)));

    p_sdr_second_r2: assert property (@(posedge clk_fast) disable iff (rst)
        (load && !mode_ddr) |=> ##1 (rise_bit == $past(hold1, 2)));

    p_expansion_r5: assert property (@(posedge clk_fast) disable iff (rst)
        (IS_MASTER && load && mode_ddr) |=> ##3
        ((rise_bit == $past(shift_in[0], 4)) && (odd_bit == $past(shift_in[1], 4))));

    p_reset_clear_r7: assert property (@(posedge clk_fast)
        rst |=> (!rise_bit && !odd_bit));

    p_slave_quiet_r6: assert property (@(posedge clk_fast) disable iff (rst)
        (!IS_MASTER) |-> (serial_q == 1'b0));

endmodule

bind txser_lane txser_lane_chk #(.IS_MASTER(IS_MASTER), .EXP_W(EXP_W)) chk_i (
    .clk_fast (clk_fast),
    .rst      (rst),
    .mode_ddr (mode_ddr),
    .load     (load_evt),
    .hold0    (hold_w[0]),
    .hold1    (hold_w[1]),
    .shift_in (shift_in),
    .rise_bit (pair_q.even),
    .odd_bit  (pair_q.odd),
    .serial_q (serial_q)
);

// File: tb/txser_lane_tb_top.sv
module txser_lane_tb_top;

    typedef struct {
        int    cyc;
        bit    hi;
        bit    val;
        string tag;
    } exp_t;

    logic       clk_fast = 1'b0;
    logic       clk_div  = 1'b0;
    logic       rst      = 1'b1;
    logic       mode_ddr = 1'b0;
    logic [5:0] m_data   = 6'h3F;
    logic [5:0] s_data   = 6'h3F;
    logic [1:0] s_shift;
    logic [1:0] m_shift;
    logic       m_line;
    logic       s_line;

    int   fc       = 0;
    int   ph       = 1;
    int   ratio    = 2;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t q[$];

    txser_lane #(.IS_MASTER(1'b1)) dut_i (
        .clk_fast (clk_fast), .clk_div (clk_div), .rst (rst), .mode_ddr (mode_ddr),
        .data_in (m_data), .shift_in (s_shift), .shift_out (m_shift), .serial_q (m_line)
    );

    txser_lane #(.IS_MASTER(1'b0)) slave_i (
        .clk_fast (clk_fast), .clk_div (clk_div), .rst (rst), .mode_ddr (mode_ddr),
        .data_in (s_data), .shift_in (2'b00), .shift_out (s_shift), .serial_q (s_line)
    );

    initial forever #4 clk_fast = ~clk_fast;

    // Divided clock derived from the fast clock, rising on phase 0.
    always @(posedge clk_fast) begin
        fc = fc + 1;
        ph = (ph + 1 >= ratio) ? 0 : ph + 1;
        clk_div <= (ph < ratio / 2);
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Driver: presents one word for the next divided edge and queues its bits.
    task automatic send_word(input logic [5:0] m, input logic [5:0] s, input string first_tag);
        logic [7:0] w;
        int         c;
        @(negedge clk_div);
        #1;
        m_data = m;
        s_data = s;
        @(posedge clk_div);
        c = fc;
        if (!mode_ddr) begin
            for (int i = 0; i < 2; i++) begin
                q.push_back('{c + 1 + i, 1'b1, m[i], (i == 0) ? first_tag : "R1"});
                q.push_back('{c + 1 + i, 1'b0, m[i], (i == 0) ? first_tag : "R1"});
            end
        end else begin
            w = {s[3], s[2], m};
            for (int j = 0; j < 4; j++) begin
                q.push_back('{c + 1 + j, 1'b1, w[2*j],   (j == 0) ? first_tag : ((j == 3) ? "R5" : "R3")});
                q.push_back('{c + 1 + j, 1'b0, w[2*j+1], (j == 3) ? "R5" : "R3"});
            end
        end
        #3;
        check(s_shift == s[3:2], "R5", "slave shift_out", int'(s_shift), int'(s[3:2]));
    endtask

    task automatic sample(input int c, input bit h);
        if (q.size() > 0 && (q[0].cyc < c || (q[0].cyc == c && q[0].hi && !h))) begin
            check(1'b0, q[0].tag, "missed bit slot", q[0].cyc, c);
            void'(q.pop_front());
        end
        if (q.size() > 0 && q[0].cyc == c && q[0].hi == h) begin
            check(m_line == q[0].val, q[0].tag, h ? "line high half" : "line low half",
                  int'(m_line), int'(q[0].val));
            void'(q.pop_front());
        end else begin
            check(m_line == 1'b0, "R7", "idle line", int'(m_line), 0);
        end
        check(s_line == 1'b0, "R6", "slave line", int'(s_line), 0);
    endtask

    // Monitor: samples mid-way through each half of every fast cycle.
    initial begin
        @(posedge clk_fast);
        forever begin
            #2 sample(fc, 1'b1);
            @(negedge clk_fast);
            #2 sample(fc, 1'b0);
            @(posedge clk_fast);
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R7: reset with nonzero inputs keeps the line and expansion taps low.
        repeat (8) @(posedge clk_fast);
        #2 check(s_shift == 2'b00, "R7", "shift_out in reset", int'(s_shift), 0);
        @(negedge clk_fast);
        m_data = '0;
        s_data = '0;
        repeat (4) @(negedge clk_fast);
        rst = 1'b0;
        repeat (6) @(posedge clk_fast);

        // 2:1 mode: R2 first bit, R1 captured values, R8 back to back.
        send_word(6'b000001, 6'b000000, "R2");
        send_word(6'b000010, 6'b111111, "R8");
        send_word(6'b111111, 6'b000000, "R8");
        send_word(6'b101110, 6'b010101, "R8");   // high bits ignored in 2:1
        send_word(6'b010001, 6'b000000, "R8");
        send_word(6'b000000, 6'b000000, "R7");
        repeat (10) @(posedge clk_fast);
        check(q.size() == 0, "R8", "queue drained 2:1", q.size(), 0);

        // Switch to 8:1 under reset.
        @(negedge clk_fast);
        rst = 1'b1;
        repeat (4) @(negedge clk_fast);
        mode_ddr = 1'b1;
        ratio    = 4;
        repeat (8) @(negedge clk_fast);
        rst = 1'b0;
        repeat (8) @(posedge clk_fast);

        // 8:1 mode: word = {s[3], s[2], m[5:0]}; slave bits 0,1,4,5 are junk.
        send_word(6'b100101, 6'b111011, "R4");   // 0xA5
        send_word(6'b000001, 6'b110011, "R8");   // 0x01
        send_word(6'b000000, 6'b001000, "R8");   // 0x80
        send_word(6'b111111, 6'b001100, "R8");   // 0xFF
        send_word(6'b111100, 6'b110000, "R8");   // 0x3C
        send_word(6'b011010, 6'b000100, "R8");   // 0x5A
        send_word(6'b000000, 6'b110011, "R7");   // slave junk only: line stays 0
        send_word(6'b000000, 6'b000000, "R7");
        repeat (12) @(posedge clk_fast);
        check(q.size() == 0, "R3", "queue drained 8:1", q.size(), 0);

        // Reset again mid-idle and confirm a fresh first word in 8:1.
        @(negedge clk_fast);
        rst = 1'b1;
        repeat (8) @(negedge clk_fast);
        rst = 1'b0;
        repeat (4) @(posedge clk_fast);
        send_word(6'b000001, 6'b000100, "R4");
        send_word(6'b000000, 6'b000000, "R7");
        repeat (12) @(posedge clk_fast);
        check(q.size() == 0, "R4", "queue drained final", q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule